// File: doc/BRIEF.md
# Byte Serializer for an External Latched Shift Register

This block moves one byte at a time from on-chip logic into an external serial-in, parallel-out shift register that has a separate output latch. The user presents a byte on `data_i` and pulses `start_i` while `ready_o` is high. The block then clocks the bits out on `ser_o` with `sclk_o`, most significant bit first. After the eighth bit it raises `rclk_o` for one pulse, so that all eight parallel outputs of the external part change together. The external part's clear pin is not driven and is assumed to stay inactive.

Every pin is timed from the system clock. The low and high phases of the shift clock, the width of the latch pulse and a short tail before the block returns to idle are parameters. With the defaults (5 + 5 cycles per bit, 5 latch cycles, 4 tail cycles), one transaction keeps `ready_o` low for 8·10 + 5 + 4 = 89 system clocks. The active-low output enable stays high after reset, so the external outputs float until the first byte has been latched. From then on it stays low.

The controller has five states. It leaves IDLE for BIT_LO when a request is accepted. BIT_LO moves to BIT_HI when the low-phase timer expires. BIT_HI moves back to BIT_LO, with a shift to the next bit, when the high-phase timer expires and bits remain. When the last bit has been clocked, BIT_HI moves to LATCH instead. LATCH moves to TAIL when the latch timer expires, and TAIL returns to IDLE when the tail timer expires.

Top module: `sipo_byte_driver`

## Requirements
- R1: After one transaction, a model of the external part (on each rising `sclk_o` it shifts its contents one place toward bit 7 and takes `ser_o` into bit 0, and on each rising `rclk_o` it copies them to the outputs) shows exactly the byte captured at acceptance. Bit 7 of `data_i` lands on output bit 7, because bits are sent MSB first.
- R2: `ready_o` is high only in IDLE. It is low from the cycle after an accepted request for exactly 8·(LO_CYC+HI_CYC)+LATCH_CYC+TAIL_CYC cycles (89 with the defaults).
- R3: `ser_o` does not change during any cycle in which `sclk_o` is high. Each bit is therefore set up for the whole low phase before the rising edge.
- R4: Each shift clock pulse is high for HI_CYC cycles, and is preceded by LO_CYC low cycles counted from acceptance or from the previous falling edge.
- R5: Exactly eight `sclk_o` rising edges occur before each `rclk_o` pulse. `rclk_o` is then high for LATCH_CYC cycles while `sclk_o` is low.
- R6: In IDLE, and during reset, `sclk_o` and `rclk_o` are low.
- R7: A `start_i` pulse seen while `ready_o` is low has no effect. The latched byte stays the accepted one, and no extra transaction follows.
- R8: `oe_n_o` is high from reset until the first latch pulse. It goes low in the cycle after `rclk_o` first rises and stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request; accepted only while ready_o is high |
| data_i | input | DATA_W (8) | Byte captured on acceptance |
| ready_o | output | 1 | High while idle and able to accept a request |
| ser_o | output | 1 | Serial data to the external register |
| sclk_o | output | 1 | Shift clock to the external register |
| rclk_o | output | 1 | Latch (storage) clock to the external register |
| oe_n_o | output | 1 | Active-low output enable of the external register |

## Verification
The bench sends several bytes: 0xA5 and 0x3C, whose mixed patterns expose bit-order and bit-position mistakes; 0x00 and 0xFF, which catch stuck serial data or a lost edge; and 0x01 and 0x80, which separate an MSB-first order from an LSB-first one. A short run of consecutive values checks that each transaction returns cleanly to IDLE and accepts the next request at once. During one transfer a second request with different data is held on the input. This separates a design that ignores requests while busy from one that reloads or queues them. Pulse widths and the length of the transaction are measured on every transfer.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_LATCH,
        ST_TAIL
    } sipo_state_e;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bit_serializer.sv
module bit_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ser_o,
    output logic              last_o
);

    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            shreg_q <= data_i;
            idx_q   <= '0;
        end else if (shift_i) begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign ser_o  = shreg_q[DATA_W-1];
    assign last_o = (idx_q == IDX_W'(DATA_W - 1));

endmodule

// File: rtl/sipo_fsm.sv
module sipo_fsm
    import sipo_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int LO_CYC    = 5,
    parameter int HI_CYC    = 5,
    parameter int LATCH_CYC = 5,
    parameter int TAIL_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tmr_zero_i,
    input  logic             ser_last_i,
    output logic             ready_o,
    output logic             sclk_o,
    output logic             rclk_o,
    output logic             oe_n_o,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             ser_load_o,
    output logic             ser_shift_o
);

    localparam logic [CNT_W-1:0] LO_LD    = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LD    = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LATCH_LD = CNT_W'(LATCH_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(TAIL_CYC - 1);

    sipo_state_e state_q, state_d;
    logic        shown_q;

    // State register (and sticky "first latch done" flag)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shown_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LATCH) begin
                shown_q <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_BIT_LO;
            ST_BIT_LO: if (tmr_zero_i) state_d = ST_BIT_HI;
            ST_BIT_HI: if (tmr_zero_i) state_d = ser_last_i ? ST_LATCH : ST_BIT_LO;
            ST_LATCH:  if (tmr_zero_i) state_d = ST_TAIL;
            ST_TAIL:   if (tmr_zero_i) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        ready_o     = 1'b0;
        sclk_o      = 1'b0;
        rclk_o      = 1'b0;
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;
        ser_load_o  = 1'b0;
        ser_shift_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o = 1'b1;
                if (start_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LO_LD;
                    ser_load_o = 1'b1;
                end
            end
            ST_BIT_LO: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HI_LD;
                end
            end
            ST_BIT_HI: begin
                sclk_o = 1'b1;
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    if (ser_last_i) begin
                        tmr_val_o = LATCH_LD;
                    end else begin
                        tmr_val_o   = LO_LD;
                        ser_shift_o = 1'b1;
                    end
                end
            end
            ST_LATCH: begin
                rclk_o = 1'b1;
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TAIL_LD;
                end
            end
            ST_TAIL: begin
            end
            default: begin
            end
        endcase
    end

    assign oe_n_o = ~shown_q;

endmodule

// File: rtl/sipo_byte_driver.sv
module sipo_byte_driver #(
    parameter int DATA_W    = 8,
    parameter int LO_CYC    = 5,
    parameter int HI_CYC    = 5,
    parameter int LATCH_CYC = 5,
    parameter int TAIL_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic              ser_o,
    output logic              sclk_o,
    output logic              rclk_o,
    output logic              oe_n_o
);

    localparam int MAX_AB = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int MAX_CD = (LATCH_CYC > TAIL_CYC) ? LATCH_CYC : TAIL_CYC;
    localparam int MAX_PH = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_PH) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             ser_load;
    logic             ser_shift;
    logic             ser_last;

    sipo_fsm #(
        .CNT_W     (CNT_W),
        .LO_CYC    (LO_CYC),
        .HI_CYC    (HI_CYC),
        .LATCH_CYC (LATCH_CYC),
        .TAIL_CYC  (TAIL_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tmr_zero_i  (tmr_zero),
        .ser_last_i  (ser_last),
        .ready_o     (ready_o),
        .sclk_o      (sclk_o),
        .rclk_o      (rclk_o),
        .oe_n_o      (oe_n_o),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .ser_load_o  (ser_load),
        .ser_shift_o (ser_shift)
    );

    phase_timer #(
        .CNT_W (CNT_W)
    ) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    bit_serializer #(
        .DATA_W (DATA_W)
    ) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ser_load),
        .shift_i (ser_shift),
        .data_i  (data_i),
        .ser_o   (ser_o),
        .last_o  (ser_last)
    );

endmodule

// File: rtl/sipo_byte_driver_chk.sv
module sipo_byte_driver_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ready_o,
    input logic ser_o,
    input logic sclk_o,
    input logic rclk_o,
    input logic oe_n_o
);

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    a_r3_ser_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(ser_o));

    a_r5_latch_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        rclk_o |-> !sclk_o);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!sclk_o && !rclk_o));

    a_r8_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |=> !oe_n_o);

    a_r8_oe_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n_o) |-> $past(rclk_o));

endmodule

bind sipo_byte_driver sipo_byte_driver_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_o (ready_o),
    .ser_o   (ser_o),
    .sclk_o  (sclk_o),
    .rclk_o  (rclk_o),
    .oe_n_o  (oe_n_o)
);

// File: tb/sipo_byte_driver_tb_top.sv
`timescale 1ns/1ps
module sipo_byte_driver_tb_top;

    localparam int LO  = 5;
    localparam int HI  = 5;
    localparam int LAT = 5;
    localparam int TL  = 4;
    localparam int TXN = 8 * (LO + HI) + LAT + TL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ready, ser, sclk, rclk, oe_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    sipo_byte_driver dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .data_i  (data),
        .ready_o (ready),
        .ser_o   (ser),
        .sclk_o  (sclk),
        .rclk_o  (rclk),
        .oe_n_o  (oe_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: external-part model and scoreboard
    logic       prev_sclk = 0, prev_rclk = 0;
    logic [7:0] ext_sr = 0;
    int         bits = 0, hi_run = 0, lo_run = 0, lat_run = 0;
    bit         seen_latch = 0, oe_pend = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (oe_pend) begin
                check(oe_n == 1'b0, "R8", "oe_n cycle after first latch", oe_n, 0);
                oe_pend = 0;
            end
            if (sclk && !prev_sclk) begin
                check(lo_run == LO, "R4", "low phase before bit", lo_run, LO);
                ext_sr = {ext_sr[6:0], ser};
                bits++;
                lo_run = 0;
            end
            if (!sclk && prev_sclk) begin
                check(hi_run == HI, "R4", "shift clock high width", hi_run, HI);
                hi_run = 0;
            end
            if (rclk && !prev_rclk) begin
                logic [7:0] e;
                check(bits == 8, "R5", "bits before latch", bits, 8);
                check(sclk == 1'b0, "R5", "sclk during latch", sclk, 0);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                check(ext_sr === e, "R1", "latched byte", ext_sr, e);
                if (!seen_latch) begin
                    check(oe_n == 1'b1, "R8", "oe_n before first latch", oe_n, 1);
                    seen_latch = 1;
                    oe_pend = 1;
                end
                bits = 0;
            end
            if (!rclk && prev_rclk) begin
                check(lat_run == LAT, "R5", "latch pulse width", lat_run, LAT);
                lat_run = 0;
            end
            if (sclk) hi_run++;
            if (rclk) lat_run++;
            if (ready) lo_run = 0;
            else if (!sclk && !rclk) lo_run++;
            if (rclk) lo_run = 0;
            prev_sclk = sclk;
            prev_rclk = rclk;
        end
    end

    // Driver: pushes expected byte, then measures the busy window
    task automatic send(input logic [7:0] d, input bit inject);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        data = d;
        start = 1'b1;
        exp_q.push_back(d);
        @(negedge clk);
        start = 1'b0;
        data = ~d;
        check(ready == 1'b0, "R2", "ready after accept", ready, 0);
        n = 0;
        while (!ready) begin
            n++;
            if (inject && n == 20) start = 1'b1;   // R7 busy request
            if (inject && n == 40) start = 1'b0;
            @(negedge clk);
        end
        check(n == TXN, "R2", "busy cycles", n, TXN);
        check(!sclk && !rclk, "R6", "idle pins", {sclk, rclk}, 0);
        if (inject) begin
            repeat (3) @(negedge clk);
            check(ready == 1'b1, "R7", "no extra transaction", ready, 1);
            check(!sclk, "R7", "no extra shift", sclk, 0);
        end
        check(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(ready == 1'b1, "R2", "ready in reset", ready, 1);
        check(!sclk && !rclk, "R6", "clocks low in reset", {sclk, rclk}, 0);
        check(oe_n == 1'b1, "R8", "oe_n in reset", oe_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(oe_n == 1'b1, "R8", "oe_n before any byte", oe_n, 1);
        send(8'hA5, 0);
        send(8'h00, 0);
        send(8'hFF, 1);
        send(8'h01, 0);
        send(8'h80, 0);
        send(8'h3C, 0);
        for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 0);
        check(oe_n == 1'b0, "R8", "oe_n stays low", oe_n, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule